// File: doc/BRIEF.md
# Two-Line Alternating-Clock Byte Receiver

This block recovers the body of a frame sent over two wires that take turns as clock and data. A falling edge on one wire samples the other wire as the next bit. Falls must strictly alternate, beginning with line A. Bits arrive most significant first. Four falls on each wire make one 8-bit byte. The byte is delivered once line A has returned high, and that moment opens the next byte slot.

A start detector elsewhere pulses `body_start_i` when a frame body begins. The receiver then collects bytes until one of two things happens. It may see the end-of-frame marker, which is a short pattern inside a byte slot. Or it may see an edge that breaks the alternation rule, which aborts the frame. In both cases it returns to idle and ignores the wires until the next start pulse. Checksum and length checks belong to a later stage.

Top module: `alt_clk_deser`

## Requirements
- R1: After reset, `byte_data_o` is 0 and `byte_valid_o`, `frame_end_o` and `frame_error_o` are all low.
- R2: Within a frame, a fall of line A shifts in the level of line B, and a fall of line B shifts in the level of line A. The first bit taken is bit 7 of the byte. After the fourth B-fall, the byte appears on `byte_data_o` with a one-cycle `byte_valid_o` once line A is seen high.
- R3: Consecutive byte slots in one frame each deliver their own byte, in order of arrival.
- R4: An A-fall is legal only when the A-fall and B-fall counts of the slot are equal. Any other A-fall, except the end marker of R7, pulses `frame_error_o` and aborts the frame.
- R5: A B-fall is legal only when the A-fall count exceeds the B-fall count by exactly one. Any other B-fall, except the one of R6, pulses `frame_error_o`.
- R6: At the very start of each byte slot, one B-fall while line A is high is ignored. A second such B-fall in the same slot is a frame error.
- R7: End marker: a first A-fall that samples 0, then a second A-fall while line B is low with no B-fall in between, then both lines high. Together these pulse `frame_end_o` for one cycle, and no byte is delivered.
- R8: Once the end marker is armed, any fall on either line before both lines are high pulses `frame_error_o` instead of `frame_end_o`.
- R9: Outside a frame (after reset, an end or an error), line activity produces no strobe until `body_start_i` is pulsed.
- R10: Simultaneous falls of both lines inside a frame are a frame error.
- R11: The three strobes last one cycle and never coincide. `byte_data_o` changes only in a cycle with `byte_valid_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, much faster than line activity |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_a_i | input | 1 | Wire A, asynchronous |
| line_b_i | input | 1 | Wire B, asynchronous |
| body_start_i | input | 1 | One-cycle pulse: a frame body begins |
| byte_data_o | output | 8 | Last received byte |
| byte_valid_o | output | 1 | One-cycle strobe for `byte_data_o` |
| frame_end_o | output | 1 | One-cycle strobe: end marker seen |
| frame_error_o | output | 1 | One-cycle strobe: ordering violated, frame aborted |

## Verification
The bench sends bytes whose first bit is 0. This forces the permitted initial B-fall. A receiver that counted that fall would shift a stray bit or flag an error, and one that allowed it twice would miss the double-skip error. It builds the end marker both cleanly and broken by an extra fall after arming. A receiver that skipped the armed wait would report an end where an error is due. It also drives equal-count B-falls, a repeated A-fall with B high, and simultaneous falls. A lax order check would go on emitting bytes in those cases instead of aborting. After an abort it toggles the wires to confirm that an idle receiver stays silent.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_GAP, ST_END} dsr_state_e;
  typedef enum logic [2:0] {EV_NONE, EV_BIT_A, EV_BIT_B, EV_SKIP, EV_END_ARM, EV_ERR} dsr_event_e;
endpackage

// File: rtl/dsr_line_sync.sv
module dsr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // lines idle high: reset to 1 so no false fall after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dsr_edge_order.sv
module dsr_edge_order
  import dsr_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] cnt_a_i,
  input  logic [CNT_W-1:0] cnt_b_i,
  input  logic             fall_a_i,
  input  logic             fall_b_i,
  input  logic             level_a_i,
  input  logic             level_b_i,
  input  logic             data_zero_i,
  input  logic             first_i,
  output dsr_event_e       event_o
);
  logic counts_eq, a_leads;

  assign counts_eq = (cnt_a_i == cnt_b_i);
  assign a_leads   = ({1'b0, cnt_a_i} == ({1'b0, cnt_b_i} + 1'b1));

  always_comb begin
    event_o = EV_NONE;
    if (fall_a_i && fall_b_i) begin
      event_o = EV_ERR;
    end else if (fall_a_i) begin
      if (counts_eq)
        event_o = EV_BIT_A;
      else if (cnt_a_i == CNT_W'(1) && cnt_b_i == '0 && data_zero_i && !level_b_i)
        event_o = EV_END_ARM;
      else
        event_o = EV_ERR;
    end else if (fall_b_i) begin
      if (a_leads)
        event_o = EV_BIT_B;
      else if (cnt_a_i == '0 && cnt_b_i == '0 && level_a_i && first_i)
        event_o = EV_SKIP;
      else
        event_o = EV_ERR;
    end
  end
endmodule

// File: rtl/dsr_byte_engine.sv
module dsr_byte_engine
  import dsr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              level_a_i,
  input  logic              level_b_i,
  input  logic              fall_a_i,
  input  logic              fall_b_i,
  input  dsr_event_e        event_i,
  output logic [CNT_W-1:0]  cnt_a_o,
  output logic [CNT_W-1:0]  cnt_b_o,
  output logic              data_zero_o,
  output logic              first_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              byte_valid_o,
  output logic              frame_end_o,
  output logic              frame_error_o
);
  localparam int PAIRS = BYTE_W / 2;
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(PAIRS - 1);

  dsr_state_e        state_q;
  logic [CNT_W-1:0]  cnt_a_q, cnt_b_q;
  logic [BYTE_W-1:0] shift_q;
  logic              first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_a_q       <= '0;
      cnt_b_q       <= '0;
      shift_q       <= '0;
      first_q       <= 1'b0;
      byte_data_o   <= '0;
      byte_valid_o  <= 1'b0;
      frame_end_o   <= 1'b0;
      frame_error_o <= 1'b0;
    end else begin
      byte_valid_o  <= 1'b0;
      frame_end_o   <= 1'b0;
      frame_error_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_a_q <= '0;
            cnt_b_q <= '0;
            shift_q <= '0;
            first_q <= 1'b1;
            state_q <= ST_SLOT;
          end
        end
        ST_SLOT: begin
          case (event_i)
            EV_BIT_A: begin
              shift_q <= {shift_q[BYTE_W-2:0], level_b_i};
              cnt_a_q <= cnt_a_q + 1'b1;
            end
            EV_BIT_B: begin
              shift_q <= {shift_q[BYTE_W-2:0], level_a_i};
              cnt_b_q <= cnt_b_q + 1'b1;
              if (cnt_b_q == LAST_B) state_q <= ST_GAP;
            end
            EV_SKIP:    first_q <= 1'b0;
            EV_END_ARM: state_q <= ST_END;
            EV_ERR: begin
              frame_error_o <= 1'b1;
              state_q       <= ST_IDLE;
            end
            default: ;
          endcase
        end
        ST_GAP: begin
          // byte released only once A is back high
          if (level_a_i) begin
            byte_data_o  <= shift_q;
            byte_valid_o <= 1'b1;
            cnt_a_q      <= '0;
            cnt_b_q      <= '0;
            shift_q      <= '0;
            first_q      <= 1'b1;
            state_q      <= ST_SLOT;
          end
        end
        ST_END: begin
          if (fall_a_i || fall_b_i) begin
            frame_error_o <= 1'b1;
            state_q       <= ST_IDLE;
          end else if (level_a_i && level_b_i) begin
            frame_end_o <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnt_a_o     = cnt_a_q;
  assign cnt_b_o     = cnt_b_q;
  assign data_zero_o = (shift_q == '0);
  assign first_o     = first_q;
endmodule

// File: rtl/alt_clk_deser.sv
module alt_clk_deser
  import dsr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_a_i,
  input  logic              line_b_i,
  input  logic              body_start_i,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              byte_valid_o,
  output logic              frame_end_o,
  output logic              frame_error_o
);
  localparam int PAIRS = BYTE_W / 2;
  localparam int CNT_W = $clog2(PAIRS + 1);

  logic [1:0] line_raw, line_lvl, line_fall;
  logic       a_lvl, b_lvl, fall_a, fall_b;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic       data_zero, first;
  dsr_event_e ev;

  assign line_raw = {line_b_i, line_a_i};

  for (genvar i = 0; i < 2; i++) begin : g_line
    dsr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_raw[i]),
      .level_o(line_lvl[i]),
      .fall_o (line_fall[i])
    );
  end

  assign a_lvl  = line_lvl[0];
  assign b_lvl  = line_lvl[1];
  assign fall_a = line_fall[0];
  assign fall_b = line_fall[1];

  dsr_edge_order #(.CNT_W(CNT_W)) u_order (
    .cnt_a_i    (cnt_a),
    .cnt_b_i    (cnt_b),
    .fall_a_i   (fall_a),
    .fall_b_i   (fall_b),
    .level_a_i  (a_lvl),
    .level_b_i  (b_lvl),
    .data_zero_i(data_zero),
    .first_i    (first),
    .event_o    (ev)
  );

  dsr_byte_engine #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (body_start_i),
    .level_a_i    (a_lvl),
    .level_b_i    (b_lvl),
    .fall_a_i     (fall_a),
    .fall_b_i     (fall_b),
    .event_i      (ev),
    .cnt_a_o      (cnt_a),
    .cnt_b_o      (cnt_b),
    .data_zero_o  (data_zero),
    .first_o      (first),
    .byte_data_o  (byte_data_o),
    .byte_valid_o (byte_valid_o),
    .frame_end_o  (frame_end_o),
    .frame_error_o(frame_error_o)
  );
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] byte_data_i,
  input logic              byte_valid_i,
  input logic              frame_end_i,
  input logic              frame_error_i,
  input logic              a_lvl_i,
  input logic              b_lvl_i,
  input logic              fall_a_i,
  input logic              fall_b_i
);
  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_i, frame_end_i, frame_error_i}));

  p_valid_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i |=> !byte_valid_i);

  p_err_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_error_i |=> !frame_error_i);

  p_data_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |-> $stable(byte_data_i));

  p_valid_a_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i |-> $past(a_lvl_i));

  p_end_lines_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |-> $past(a_lvl_i && b_lvl_i));

  p_err_from_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_error_i |-> $past(fall_a_i || fall_b_i));
endmodule

bind alt_clk_deser dsr_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_data_i  (byte_data_o),
  .byte_valid_i (byte_valid_o),
  .frame_end_i  (frame_end_o),
  .frame_error_i(frame_error_o),
  .a_lvl_i      (a_lvl),
  .b_lvl_i      (b_lvl),
  .fall_a_i     (fall_a),
  .fall_b_i     (fall_b)
);

// File: tb/sim_alt_clk_deser.sv
module sim_alt_clk_deser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       la = 1'b1, lb = 1'b1, start = 1'b0;
  logic [7:0] byte_data;
  logic       byte_valid, frame_end, frame_error;

  int n_cmp = 0, n_bad = 0;
  int n_valid = 0, n_end = 0, n_err = 0, n_strobe_bad = 0, cyc = 0;
  logic [7:0] got [16];
  logic       v_q = 1'b0, e_q = 1'b0;
  logic [7:0] d_q = 8'h00;

  always #5 clk = ~clk;

  alt_clk_deser u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_a_i(la), .line_b_i(lb),
    .body_start_i(start), .byte_data_o(byte_data), .byte_valid_o(byte_valid),
    .frame_end_o(frame_end), .frame_error_o(frame_error)
  );

  // monitor, 2 ns after the active edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (byte_valid) begin got[n_valid % 16] = byte_data; n_valid++; end
      if (frame_end) n_end++;
      if (frame_error) n_err++;
      if ((int'(byte_valid) + int'(frame_end) + int'(frame_error)) > 1) n_strobe_bad++;
      if ((byte_valid && v_q) || (frame_error && e_q)) n_strobe_bad++;
      if (!byte_valid && byte_data !== d_q) n_strobe_bad++;
      v_q = byte_valid; e_q = frame_error; d_q = byte_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish actual=%0d expected<%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drv(input logic a, input logic b);
    @(negedge clk);
    la = a; lb = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic begin_frame();
    drv(1'b1, 1'b1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 0; k < 4; k++) begin
      drv(la, v[7-2*k]);   // data on B (may be the allowed initial B-fall)
      drv(1'b0, lb);       // A-fall samples B
      drv(v[6-2*k], lb);   // data on A
      drv(la, 1'b1);
      drv(la, 1'b0);       // B-fall samples A
      drv(1'b1, lb);
    end
  endtask

  task automatic send_end();
    drv(la, 1'b0);
    drv(1'b0, 1'b0);       // A-fall samples 0
    drv(1'b1, 1'b0);
    drv(1'b0, 1'b0);       // second A-fall, B low: arm
    drv(1'b1, 1'b0);
    drv(1'b1, 1'b1);       // both high
  endtask

  task automatic t_reset();
    chk("R1 byte_data", int'(byte_data), 0);
    chk("R1 strobes", int'({byte_valid, frame_end, frame_error}), 0);
  endtask

  task automatic t_two_bytes();
    int v0 = n_valid, e0 = n_end, r0 = n_err;
    begin_frame();
    send_byte(8'hA5);
    send_byte(8'h3C);
    send_end();
    chk("R3 byte count", n_valid - v0, 2);
    chk("R2 first byte", int'(got[v0 % 16]), 'hA5);
    chk("R3 second byte", int'(got[(v0+1) % 16]), 'h3C);
    chk("R7 end strobe", n_end - e0, 1);
    chk("R7 no error", n_err - r0, 0);
  endtask

  task automatic t_skip();
    int v0 = n_valid, e0 = n_end;
    begin_frame();
    send_byte(8'h00);      // first bit 0: initial B-fall ignored (R6)
    send_byte(8'h81);
    send_end();
    chk("R6 skip byte0", int'(got[v0 % 16]), 'h00);
    chk("R2 byte1", int'(got[(v0+1) % 16]), 'h81);
    chk("R7 end after skip", n_end - e0, 1);
  endtask

  task automatic t_bad_a();
    int v0 = n_valid, r0 = n_err;
    begin_frame();
    drv(1'b0, 1'b1);
    drv(1'b1, 1'b1);
    drv(1'b0, 1'b1);       // second A-fall with B high
    chk("R4 error", n_err - r0, 1);
    chk("R4 no byte", n_valid - v0, 0);
  endtask

  task automatic t_bad_b();
    int r0 = n_err;
    begin_frame();
    drv(1'b0, 1'b1);
    drv(1'b0, 1'b0);       // legal B-fall
    drv(1'b0, 1'b1);
    drv(1'b0, 1'b0);       // B-fall with equal counts
    chk("R5 error", n_err - r0, 1);
  endtask

  task automatic t_double_skip();
    int r0 = n_err;
    begin_frame();
    drv(1'b1, 1'b0);
    drv(1'b1, 1'b1);
    drv(1'b1, 1'b0);
    chk("R6 second skip error", n_err - r0, 1);
  endtask

  task automatic t_end_break();
    int r0 = n_err, e0 = n_end;
    begin_frame();
    drv(1'b1, 1'b0);
    drv(1'b0, 1'b0);
    drv(1'b1, 1'b0);
    drv(1'b0, 1'b0);       // armed
    drv(1'b1, 1'b0);
    drv(1'b0, 1'b0);       // stray A-fall
    drv(1'b1, 1'b1);
    chk("R8 error", n_err - r0, 1);
    chk("R8 no end", n_end - e0, 0);
  endtask

  task automatic t_idle();
    int v0 = n_valid, e0 = n_end, r0 = n_err;
    drv(1'b0, 1'b1);
    drv(1'b1, 1'b0);
    drv(1'b0, 1'b0);
    drv(1'b1, 1'b1);
    drv(1'b0, 1'b0);
    drv(1'b1, 1'b1);
    chk("R9 silent", (n_valid - v0) + (n_end - e0) + (n_err - r0), 0);
    chk("R11 data held", int'(byte_data), 'h81);
  endtask

  task automatic t_simul();
    int r0 = n_err;
    begin_frame();
    drv(1'b0, 1'b0);
    chk("R10 error", n_err - r0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_two_bytes();
    t_skip();
    t_bad_a();
    t_bad_b();
    t_double_skip();
    t_end_break();
    t_idle();
    t_simul();
    drv(1'b1, 1'b1);
    chk("R11 strobe shape", n_strobe_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule